// File: doc/BRIEF.md
# Keyed Clock Stop Controller

This block holds a single 32-bit control word on a simple peripheral register bus. Software uses it to halt up to three downstream clocks: the bus-interface clock, the local bus clock and a feedback clock. Only two low-order bits can be stored. A write takes effect only if the top byte of the write data carries a fixed unlock key, so stray or corrupted writes cannot stop a clock by accident. A power-on reset clears the word. A software reset leaves it untouched, so a halted clock stays halted across a soft restart.

A static strap input tells the block where the bus-interface clock comes from. With the dedicated external pin as the source, one bit halts the bus-interface clock and the other halts only the local clock. With the CPU clock output pin as the source, the bus-interface bit does nothing, and the local-clock bit halts both the local clock and the feedback clock. Each run request passes through a two-flop synchroniser in its own clock domain. It then drives a latch-based clock gate whose latch is open only while that clock is low, so every gated pulse has full width.

Top module: `keyed_clock_halt`

## Requirements
- R1: A bus write with `regValid`=1, `regWrite`=1, `regAddr` equal to `REG_OFFSET` (default 0x10), `regWdata[31:24]` equal to `KEY` (default 0xA5) and `swRst`=0 loads `regWdata[1:0]` into the control word at that `regClk` edge. A read in the following cycle returns the new value.
- R2: A write whose key byte differs from `KEY`, or whose address differs from `REG_OFFSET`, leaves the control word unchanged.
- R3: Bits 31:2 of the control word always read as 0, whatever value was written to them.
- R4: `porRstN` low clears the control word to 0x00000000 asynchronously. A `swRst` pulse does not change it, and a write presented while `swRst` is 1 is ignored.
- R5: A read (`regValid`=1, `regWrite`=0) at `REG_OFFSET` returns the control word on `regRdata` combinationally in the same cycle. `regRdata` is 0 for reads of any other offset and whenever no read is presented.
- R6: With `srcMode`=0 (external-pin source), bit 1 set stops `ifClkGated`, and bit 0 has no effect on `fbClkGated`.
- R7: With either `srcMode`, bit 0 set stops `localClkGated`. Clearing it restarts that clock.
- R8: With `srcMode`=1 (CPU-clock-pin source), bit 0 set also stops `fbClkGated`, and bit 1 has no effect on `ifClkGated`.
- R9: After the control word changes, a gated clock issues at most three more rising edges before it stops, because of the two-flop synchroniser in the target domain.
- R10: Every high pulse on a gated output lasts exactly one full high phase of its source clock. No runt pulse occurs when a clock is stopped or restarted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| regClk | input | 1 | Register bus clock |
| porRstN | input | 1 | Power-on reset, active low, asynchronous |
| swRst | input | 1 | Software reset, active high; blocks writes, keeps contents |
| regValid | input | 1 | Bus access valid this cycle |
| regWrite | input | 1 | 1 = write, 0 = read |
| regAddr | input | ADDR_W | Register offset |
| regWdata | input | 32 | Write data; bits 31:24 carry the key |
| regRdata | output | 32 | Read data, combinational |
| srcMode | input | 1 | 0 = external pin source, 1 = CPU clock pin source |
| ifClk | input | 1 | Bus-interface source clock |
| localClk | input | 1 | Local bus source clock |
| fbClk | input | 1 | Feedback source clock |
| ifClkGated | output | 1 | Gated bus-interface clock |
| localClkGated | output | 1 | Gated local bus clock |
| fbClkGated | output | 1 | Gated feedback clock |

## Verification
Register results are due at two different times. Read data is due in the same cycle as the read, so the bench samples it 1 ns after the driving negative edge. A write is visible at the first rising `regClk` edge, so the bench reads it back starting one cycle later. A clock stop or restart is due within three rising edges of the target clock. The bench therefore waits 80 ns, which covers at least five periods of the slowest gated clock, before it counts edges over a 60 ns window. It checks the upper bound of R9 separately, right after the write. Pulse widths are measured on every gated edge throughout the run and compared with the source half period.

// File: rtl/keyed_clock_halt_pkg.sv
`timescale 1ns/1ps
package keyed_clock_halt_pkg;
  localparam int DATA_W = 32;
  localparam int KEY_W = 8;
  localparam int CTRL_BITS = 2;
  localparam int IF_STOP_BIT = 1;
  localparam int LOCAL_STOP_BIT = 0;
  localparam int NUM_DOM = 3;
  localparam int DOM_IF = 0;
  localparam int DOM_LOCAL = 1;
  localparam int DOM_FB = 2;

  typedef enum logic {SRC_EXT_PIN = 1'b0, SRC_CPU_PIN = 1'b1} clkSrc_t;

  typedef struct packed {
    logic wrStb;
    logic rdStb;
  } regStb_t;
endpackage

// File: rtl/keyed_clock_halt_ctrl.sv
`timescale 1ns/1ps
module keyed_clock_halt_ctrl
  import keyed_clock_halt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic                 regValid,
  input  logic                 regWrite,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [KEY_W-1:0]     keyByte,
  input  logic                 swRst,
  input  logic                 srcMode,
  input  logic [CTRL_BITS-1:0] stopBits,
  output regStb_t              stb,
  output logic [NUM_DOM-1:0]   runReq
);
  logic hit;
  logic keyOk;
  clkSrc_t src;

  assign hit   = regValid && (regAddr == REG_OFFSET);
  assign keyOk = (keyByte == KEY);
  assign src   = clkSrc_t'(srcMode);

  always_comb begin
    stb.wrStb = hit && regWrite && keyOk && !swRst;
    stb.rdStb = hit && !regWrite;
  end

  // Source-dependent mapping of stop bits onto the three clock domains.
  always_comb begin
    runReq = '1;
    if (src == SRC_EXT_PIN) begin
      runReq[DOM_IF]    = !stopBits[IF_STOP_BIT];
      runReq[DOM_LOCAL] = !stopBits[LOCAL_STOP_BIT];
    end else begin
      runReq[DOM_LOCAL] = !stopBits[LOCAL_STOP_BIT];
      runReq[DOM_FB]    = !stopBits[LOCAL_STOP_BIT];
    end
  end
endmodule

// File: rtl/keyed_clock_halt_dp.sv
`timescale 1ns/1ps
module keyed_clock_halt_dp
  import keyed_clock_halt_pkg::*;
(
  input  logic                 regClk,
  input  logic                 porRstN,
  input  regStb_t              stb,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rdata,
  output logic [CTRL_BITS-1:0] stopBits
);
  localparam logic [DATA_W-1:0] WR_MASK = DATA_W'((1 << CTRL_BITS) - 1);

  logic [DATA_W-1:0] ctrlQ;

  always_ff @(posedge regClk or negedge porRstN) begin
    if (!porRstN) ctrlQ <= '0;
    else if (stb.wrStb) ctrlQ <= wdata & WR_MASK;
  end

  assign rdata    = stb.rdStb ? ctrlQ : '0;
  assign stopBits = ctrlQ[CTRL_BITS-1:0];
endmodule

// File: rtl/keyed_clock_halt_gate.sv
`timescale 1ns/1ps
module keyed_clock_halt_gate #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clkIn,
  input  logic porRstN,
  input  logic runReq,
  output logic clkOut
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic enLat;

  always_ff @(posedge clkIn or negedge porRstN) begin
    if (!porRstN) syncQ <= '1;
    else syncQ <= {syncQ[SYNC_STAGES-2:0], runReq};
  end

  // Latch open only during the low phase: the enable settles before the rise.
  always_latch begin
    if (!porRstN) enLat = 1'b1;
    else if (!clkIn) enLat = syncQ[SYNC_STAGES-1];
  end

  assign clkOut = clkIn & enLat;
endmodule

// File: rtl/keyed_clock_halt.sv
`timescale 1ns/1ps
module keyed_clock_halt
  import keyed_clock_halt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input  logic              regClk,
  input  logic              porRstN,
  input  logic              swRst,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              srcMode,
  input  logic              ifClk,
  input  logic              localClk,
  input  logic              fbClk,
  output logic              ifClkGated,
  output logic              localClkGated,
  output logic              fbClkGated
);
  regStb_t stb;
  logic [CTRL_BITS-1:0] stopBits;
  logic [NUM_DOM-1:0] runReq;
  logic [NUM_DOM-1:0] srcClks;
  logic [NUM_DOM-1:0] gatedClks;

  keyed_clock_halt_ctrl #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .KEY(KEY)) ctrl_i (
    .regValid(regValid), .regWrite(regWrite), .regAddr(regAddr),
    .keyByte(regWdata[DATA_W-1 -: KEY_W]), .swRst(swRst), .srcMode(srcMode),
    .stopBits(stopBits), .stb(stb), .runReq(runReq)
  );

  keyed_clock_halt_dp dp_i (
    .regClk(regClk), .porRstN(porRstN), .stb(stb), .wdata(regWdata),
    .rdata(regRdata), .stopBits(stopBits)
  );

  assign srcClks[DOM_IF]    = ifClk;
  assign srcClks[DOM_LOCAL] = localClk;
  assign srcClks[DOM_FB]    = fbClk;

  for (genvar d = 0; d < NUM_DOM; d++) begin : gDom
    keyed_clock_halt_gate #(.SYNC_STAGES(2)) gate_i (
      .clkIn(srcClks[d]), .porRstN(porRstN), .runReq(runReq[d]), .clkOut(gatedClks[d])
    );
  end

  assign ifClkGated    = gatedClks[DOM_IF];
  assign localClkGated = gatedClks[DOM_LOCAL];
  assign fbClkGated    = gatedClks[DOM_FB];
endmodule

// File: rtl/keyed_clock_halt_chk.sv
`timescale 1ns/1ps
module keyed_clock_halt_chk
  import keyed_clock_halt_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_OFFSET = 'h10,
  parameter logic [KEY_W-1:0] KEY = 8'hA5
) (
  input logic                 regClk,
  input logic                 porRstN,
  input logic                 swRst,
  input logic                 regValid,
  input logic                 regWrite,
  input logic [ADDR_W-1:0]    regAddr,
  input logic [DATA_W-1:0]    regWdata,
  input logic [DATA_W-1:0]    regRdata,
  input logic [CTRL_BITS-1:0] stopBits
);
  logic goodWr;
  logic badWr;
  assign goodWr = regValid && regWrite && !swRst && regAddr == REG_OFFSET &&
                  regWdata[DATA_W-1 -: KEY_W] == KEY;
  assign badWr  = regValid && regWrite &&
                  (regAddr != REG_OFFSET || regWdata[DATA_W-1 -: KEY_W] != KEY);

  AST_KEYED_WRITE_LOADS: assert property (@(posedge regClk) disable iff (!porRstN)
    goodWr |=> stopBits == $past(regWdata[CTRL_BITS-1:0])); // R1
  AST_REJECTED_WRITE_HOLDS: assert property (@(posedge regClk) disable iff (!porRstN)
    badWr |=> $stable(stopBits)); // R2
  AST_RESERVED_READ_ZERO: assert property (@(posedge regClk) disable iff (!porRstN)
    regRdata[DATA_W-1:CTRL_BITS] == '0); // R3
  AST_SOFT_RESET_KEEPS: assert property (@(posedge regClk) disable iff (!porRstN)
    swRst |=> $stable(stopBits)); // R4
  AST_READ_RETURNS_WORD: assert property (@(posedge regClk) disable iff (!porRstN)
    (regValid && !regWrite && regAddr == REG_OFFSET) |-> regRdata[CTRL_BITS-1:0] == stopBits); // R5
  AST_MISS_READ_ZERO: assert property (@(posedge regClk) disable iff (!porRstN)
    !(regValid && !regWrite && regAddr == REG_OFFSET) |-> regRdata == '0); // R5
endmodule

bind keyed_clock_halt keyed_clock_halt_chk #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET), .KEY(KEY)) chk_i (
  .regClk(regClk), .porRstN(porRstN), .swRst(swRst), .regValid(regValid),
  .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata),
  .regRdata(regRdata), .stopBits(stopBits)
);

// File: tb/keyed_clock_halt_tb_top.sv
`timescale 1ns/1ps
module keyed_clock_halt_tb_top;
  localparam logic [7:0] OFF = 8'h10;
  localparam real IF_HALF = 3.0;
  localparam real LOC_HALF = 5.0;
  localparam real FB_HALF = 7.0;

  logic regClk = 0, porRstN = 0, swRst = 0;
  logic regValid = 0, regWrite = 0;
  logic [7:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic srcMode = 0;
  logic ifClk = 0, localClk = 0, fbClk = 0;
  logic ifClkGated, localClkGated, fbClkGated;

  int checks = 0, fails = 0;
  int ifEdges = 0, locEdges = 0, fbEdges = 0, runts = 0;
  real ifRise = 0, locRise = 0, fbRise = 0;
  bit done = 0;

  always #2 regClk = ~regClk;
  always #(IF_HALF) ifClk = ~ifClk;
  always #(LOC_HALF) localClk = ~localClk;
  always #(FB_HALF) fbClk = ~fbClk;

  keyed_clock_halt dut_i (
    .regClk(regClk), .porRstN(porRstN), .swRst(swRst), .regValid(regValid),
    .regWrite(regWrite), .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .srcMode(srcMode), .ifClk(ifClk), .localClk(localClk), .fbClk(fbClk),
    .ifClkGated(ifClkGated), .localClkGated(localClkGated), .fbClkGated(fbClkGated)
  );

  // R10: pulse-width monitors
  always @(posedge ifClkGated) begin ifEdges++; ifRise = $realtime; end
  always @(posedge localClkGated) begin locEdges++; locRise = $realtime; end
  always @(posedge fbClkGated) begin fbEdges++; fbRise = $realtime; end
  always @(negedge ifClkGated)
    if (porRstN && ifRise > 0 && (($realtime - ifRise) < IF_HALF - 0.01 || ($realtime - ifRise) > IF_HALF + 0.01)) runts++;
  always @(negedge localClkGated)
    if (porRstN && locRise > 0 && (($realtime - locRise) < LOC_HALF - 0.01 || ($realtime - locRise) > LOC_HALF + 0.01)) runts++;
  always @(negedge fbClkGated)
    if (porRstN && fbRise > 0 && (($realtime - fbRise) < FB_HALF - 0.01 || ($realtime - fbRise) > FB_HALF + 0.01)) runts++;

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge regClk); regValid = 1; regWrite = 1; regAddr = a; regWdata = d;
    @(negedge regClk); regValid = 0; regWrite = 0; regWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    @(negedge regClk); regValid = 1; regWrite = 0; regAddr = a;
    #1 d = regRdata;
    @(negedge regClk); regValid = 0;
  endtask

  task automatic porPulse();
    @(negedge regClk); porRstN = 0;
    repeat (3) @(negedge regClk);
    porRstN = 1;
  endtask

  task automatic expectRun(input string tag, input bit expIf, input bit expLoc, input bit expFb);
    int i0, l0, f0;
    #80;
    i0 = ifEdges; l0 = locEdges; f0 = fbEdges;
    #60;
    check((ifEdges != i0) == expIf, {tag, " ifClkGated"}, 32'(ifEdges - i0), 32'(expIf));
    check((locEdges != l0) == expLoc, {tag, " localClkGated"}, 32'(locEdges - l0), 32'(expLoc));
    check((fbEdges != f0) == expFb, {tag, " fbClkGated"}, 32'(fbEdges - f0), 32'(expFb));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check(regRdata == 0, "R5 idle rdata", regRdata, 0);
    busRead(OFF, d);
    check(d == 0, "R4 word after power-on reset", d, 0);
    expectRun("R4 all clocks run after reset", 1, 1, 1);
  endtask

  task automatic t_keyedWrite();
    logic [31:0] d;
    busWrite(OFF, 32'hA500_0002);
    busRead(OFF, d);
    check(d == 32'h2, "R1 keyed write value 2", d, 32'h2);
    busWrite(OFF, 32'hA5FF_FFFF);
    busRead(OFF, d);
    check(d == 32'h3, "R3 reserved bits read zero", d, 32'h3);
    busWrite(OFF, 32'hA5FF_FFFC);
    busRead(OFF, d);
    check(d == 32'h0, "R1 keyed write clears", d, 0);
  endtask

  task automatic t_badKey();
    logic [31:0] d;
    busWrite(OFF, 32'h5A00_0003);
    busRead(OFF, d);
    check(d == 0, "R2 key 0x5A ignored", d, 0);
    busWrite(OFF, 32'hA400_0003);
    busRead(OFF, d);
    check(d == 0, "R2 key 0xA4 ignored", d, 0);
    busWrite(OFF + 8'h4, 32'hA500_0003);
    busRead(OFF, d);
    check(d == 0, "R2 wrong offset ignored", d, 0);
    busWrite(OFF, 32'hA500_0001);
    busRead(OFF + 8'h4, d);
    check(d == 0, "R5 other offset reads zero", d, 0);
    busWrite(OFF, 32'h0000_0000);
    busRead(OFF, d);
    check(d == 32'h1, "R2 keyless clear ignored", d, 32'h1);
  endtask

  task automatic t_softReset();
    logic [31:0] d;
    busWrite(OFF, 32'hA500_0002);
    @(negedge regClk); swRst = 1;
    repeat (2) @(negedge regClk);
    swRst = 0;
    busRead(OFF, d);
    check(d == 32'h2, "R4 soft reset keeps word", d, 32'h2);
    @(negedge regClk); swRst = 1; regValid = 1; regWrite = 1; regAddr = OFF; regWdata = 32'hA500_0001;
    @(negedge regClk); swRst = 0; regValid = 0; regWrite = 0;
    busRead(OFF, d);
    check(d == 32'h2, "R4 write during soft reset ignored", d, 32'h2);
    porPulse();
    busRead(OFF, d);
    check(d == 0, "R4 power-on reset clears", d, 0);
  endtask

  task automatic t_extMode();
    int l0;
    srcMode = 0;
    busWrite(OFF, 32'hA500_0002);
    expectRun("R6 ext bit1", 0, 1, 1);
    busWrite(OFF, 32'hA500_0001);
    l0 = locEdges;
    #80;
    check(locEdges - l0 <= 3, "R9 stop latency", 32'(locEdges - l0), 3);
    expectRun("R7 R6 ext bit0", 1, 0, 1);
    busWrite(OFF, 32'hA500_0000);
    expectRun("R7 ext restart", 1, 1, 1);
  endtask

  task automatic t_cpuMode();
    srcMode = 1;
    busWrite(OFF, 32'hA500_0002);
    expectRun("R8 cpu bit1 no effect", 1, 1, 1);
    busWrite(OFF, 32'hA500_0001);
    expectRun("R8 R7 cpu bit0", 1, 0, 0);
    busWrite(OFF, 32'hA500_0000);
    expectRun("R8 cpu restart", 1, 1, 1);
  endtask

  initial begin
    #800000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #21 porRstN = 1;
    t_reset();
    t_keyedWrite();
    t_badKey();
    t_softReset();
    t_extMode();
    t_cpuMode();
    check(runts == 0, "R10 no runt pulses", 32'(runts), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule